// File: doc/BRIEF.md
# Banked Interrupt Priority Register File

This block holds one 8-bit priority value per interrupt line for a multi-processor interrupt controller. The register port addresses the store by byte. The byte offset of an access is the interrupt number, and one access covers 1, 2 or 4 consecutive interrupts. Byte 0 of the data belongs to the addressed interrupt, and each higher byte belongs to the next interrupt number.

Every access carries the identifier of the processor that makes it. For interrupt numbers below 32, that identifier selects the processor's own private copy of the priority bytes. For interrupt numbers of 32 and above, all processors see one shared copy. A single access may cross the boundary at 32, so part of it lands in the private copy and the rest in the shared copy.

A separate combinational lookup port lets the arbitration logic read the priority of any interrupt as seen by any processor. Illegal accesses are rejected with an error response.

Top module: `prio_bank_regfile`

## Requirements
- R1: After reset, every priority byte reads as 0, in every private copy and in the shared copy.
- R2: An access to interrupt numbers 0 to 31 reads or writes only the private copy of the processor named on `req_cpu`. Other processors' copies are unaffected.
- R3: An access to interrupt numbers 32 and above reads or writes the single shared copy, whichever processor makes it.
- R4: `req_size` encodes the byte count directly: 1, 2 or 4. Data bits [8k+7:8k] map to interrupt `req_addr + k` for k below the size. Bytes at or above the size are not written, and they read back as 0. A write response carries zero read data.
- R5: A `req_size` other than 1, 2 or 4 gives `rsp_err` = 1 and zero read data, and no priority byte changes.
- R6: An access with `req_addr + req_size` greater than `NUM_IRQS` (default 64) gives `rsp_err` = 1 and zero read data, and no priority byte changes. An access that ends exactly at `NUM_IRQS` is legal.
- R7: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high. A write takes effect on the edge that accepts it, so a read in the very next cycle returns the new value.
- R8: `lk_prio` gives, with no clock delay, the priority of interrupt `lk_irq` as seen by processor `lk_cpu`. It uses that processor's private copy below 32 and the shared copy otherwise.
- R9: A multi-byte access that spans interrupt 31 and 32 writes its low lanes into the requester's private copy and its high lanes into the shared copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | CPU_W (2) | Requesting processor identifier |
| req_addr | input | ADDR_W (8) | Byte offset = first interrupt number |
| req_size | input | 3 | Byte count: 1, 2 or 4 |
| req_wdata | input | 32 | Write data, one byte per lane |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_err | output | 1 | Illegal access |
| rsp_rdata | output | 32 | Read data, one byte per lane |
| lk_cpu | input | CPU_W (2) | Lookup processor |
| lk_irq | input | IRQ_W (6) | Lookup interrupt number |
| lk_prio | output | 8 | Priority of the looked-up interrupt |

## Verification
The bench writes distinct values to the same low interrupt numbers from different processors. A design that ignored the requester for banked numbers would return the last writer's bytes to every processor. Reads of shared numbers from several processors catch a design that banked too many lines. An access that straddles 31 and 32, and unaligned single-byte and half-word accesses, catch lane-to-interrupt mapping errors and missing zero fill in the upper bytes. Illegal sizes, an access that overruns the last interrupt by two, and one that ends exactly at it would expose a design that still wrote on error or rejected the legal edge. A write followed at once by a read shows whether the write landed on its own edge.

// File: rtl/prio_bank_pkg.sv
package prio_bank_pkg;
   localparam int LANES  = 4;
   localparam int BYTE_W = 8;
   localparam int DATA_W = LANES * BYTE_W;

   typedef enum logic [2:0] {
      SZ_BYTE = 3'd1,
      SZ_HALF = 3'd2,
      SZ_WORD = 3'd4
   } acc_size_e;

   function automatic logic size_legal(input logic [2:0] s);
      return (s == SZ_BYTE) || (s == SZ_HALF) || (s == SZ_WORD);
   endfunction
endpackage

// File: rtl/prio_req_decode.sv
module prio_req_decode
   import prio_bank_pkg::*;
#(
   parameter int NUM_CPUS   = 4,
   parameter int NUM_IRQS   = 64,
   parameter int NUM_BANKED = 32,
   parameter int ADDR_W     = 8,
   localparam int CPU_W  = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
   localparam int BANK_W = $clog2(NUM_BANKED),
   localparam int SH_W   = $clog2(NUM_IRQS - NUM_BANKED)
) (
   input  logic [CPU_W-1:0]        req_cpu,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [2:0]              req_size,
   output logic                    err,
   output logic [LANES-1:0]        lane_act,
   output logic [LANES-1:0]        lane_banked,
   output logic [LANES*BANK_W-1:0] lane_bidx,
   output logic [LANES*SH_W-1:0]   lane_sidx
);
   logic size_ok, cpu_ok, range_ok;

   assign size_ok  = size_legal(req_size);
   assign cpu_ok   = int'(req_cpu) < NUM_CPUS;
   assign range_ok = (int'(req_addr) + int'(req_size)) <= NUM_IRQS;
   assign err      = !(size_ok && cpu_ok && range_ok);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      int lane_num;
      assign lane_num       = int'(req_addr) + l;
      assign lane_act[l]    = !err && (l < int'(req_size));
      assign lane_banked[l] = lane_num < NUM_BANKED;
      assign lane_bidx[l*BANK_W +: BANK_W] = BANK_W'(lane_num);
      assign lane_sidx[l*SH_W +: SH_W]     = SH_W'(lane_num - NUM_BANKED);

      always_comb begin
         if (lane_act[l]) begin
            p_lane_in_range_r6: assert (lane_num < NUM_IRQS);
         end
      end
   end
endmodule

// File: rtl/prio_byte_array.sv
module prio_byte_array
   import prio_bank_pkg::*;
#(
   parameter int DEPTH = 32,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        wr_en,
   input  logic [LANES*IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0]       wr_data,
   output logic [DATA_W-1:0]       rd_data,
   input  logic [IDX_W-1:0]        lk_idx,
   output logic [BYTE_W-1:0]       lk_data
);
   logic [BYTE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         for (int l = 0; l < LANES; l++) begin
            if (wr_en[l]) mem[idx[l*IDX_W +: IDX_W]] <= wr_data[l*BYTE_W +: BYTE_W];
         end
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_rd
      assign rd_data[l*BYTE_W +: BYTE_W] = mem[idx[l*IDX_W +: IDX_W]];
   end

   assign lk_data = mem[lk_idx];

   p_hold_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en == '0) ##1 $stable(lk_idx) |-> $stable(lk_data));
endmodule

// File: rtl/prio_read_merge.sv
module prio_read_merge
   import prio_bank_pkg::*;
#(
   parameter int NUM_CPUS   = 4,
   parameter int NUM_IRQS   = 64,
   parameter int NUM_BANKED = 32,
   localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
   localparam int IRQ_W = $clog2(NUM_IRQS)
) (
   input  logic [CPU_W-1:0]               req_cpu,
   input  logic [LANES-1:0]               lane_act,
   input  logic [LANES-1:0]               lane_banked,
   input  logic [NUM_CPUS*DATA_W-1:0]     bank_rd,
   input  logic [DATA_W-1:0]              shr_rd,
   input  logic [CPU_W-1:0]               lk_cpu,
   input  logic [IRQ_W-1:0]               lk_irq,
   input  logic [NUM_CPUS*BYTE_W-1:0]     bank_lk,
   input  logic [BYTE_W-1:0]              shr_lk,
   output logic [DATA_W-1:0]              rd_word,
   output logic [BYTE_W-1:0]              lk_prio
);
   always_comb begin
      rd_word = '0;
      for (int l = 0; l < LANES; l++) begin
         if (lane_act[l]) begin
            if (lane_banked[l]) begin
               for (int c = 0; c < NUM_CPUS; c++) begin
                  if (req_cpu == CPU_W'(c))
                     rd_word[l*BYTE_W +: BYTE_W] = bank_rd[(c*LANES + l)*BYTE_W +: BYTE_W];
               end
            end else begin
               rd_word[l*BYTE_W +: BYTE_W] = shr_rd[l*BYTE_W +: BYTE_W];
            end
         end
      end
   end

   always_comb begin
      lk_prio = '0;
      if (int'(lk_irq) < NUM_BANKED) begin
         for (int c = 0; c < NUM_CPUS; c++) begin
            if (lk_cpu == CPU_W'(c)) lk_prio = bank_lk[c*BYTE_W +: BYTE_W];
         end
      end else if (int'(lk_irq) < NUM_IRQS) begin
         lk_prio = shr_lk;
      end
   end
endmodule

// File: rtl/prio_bank_regfile.sv
module prio_bank_regfile
   import prio_bank_pkg::*;
#(
   parameter int NUM_CPUS   = 4,
   parameter int NUM_IRQS   = 64,
   parameter int NUM_BANKED = 32,
   parameter int ADDR_W     = 8,
   localparam int CPU_W  = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
   localparam int IRQ_W  = $clog2(NUM_IRQS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [CPU_W-1:0]  req_cpu,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_size,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [31:0]       rsp_rdata,
   input  logic [CPU_W-1:0]  lk_cpu,
   input  logic [IRQ_W-1:0]  lk_irq,
   output logic [7:0]        lk_prio
);
   localparam int NUM_SHARED = NUM_IRQS - NUM_BANKED;
   localparam int BANK_W     = $clog2(NUM_BANKED);
   localparam int SH_W       = $clog2(NUM_SHARED);

   if (NUM_BANKED != (1 << BANK_W)) begin : g_bad_banked
      $error("NUM_BANKED must be a power of two");
   end
   if (NUM_SHARED < 2) begin : g_bad_shared
      $error("NUM_IRQS must exceed NUM_BANKED by at least two");
   end
   if (NUM_IRQS > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for NUM_IRQS");
   end
   if (NUM_CPUS < 1) begin : g_bad_cpus
      $error("NUM_CPUS must be at least one");
   end

   logic                    dec_err;
   logic [LANES-1:0]        lane_act, lane_banked;
   logic [LANES*BANK_W-1:0] lane_bidx;
   logic [LANES*SH_W-1:0]   lane_sidx;
   logic                    wr_fire;

   logic [NUM_CPUS*DATA_W-1:0] bank_rd;
   logic [NUM_CPUS*BYTE_W-1:0] bank_lk;
   logic [DATA_W-1:0]          shr_rd, rd_word;
   logic [BYTE_W-1:0]          shr_lk;
   logic [LANES-1:0]           shr_we;

   prio_req_decode #(
      .NUM_CPUS(NUM_CPUS), .NUM_IRQS(NUM_IRQS),
      .NUM_BANKED(NUM_BANKED), .ADDR_W(ADDR_W)
   ) u_dec (
      .req_cpu(req_cpu), .req_addr(req_addr), .req_size(req_size),
      .err(dec_err), .lane_act(lane_act), .lane_banked(lane_banked),
      .lane_bidx(lane_bidx), .lane_sidx(lane_sidx)
   );

   assign wr_fire = req_valid && req_write;

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      logic [LANES-1:0] we;
      assign we = (wr_fire && (req_cpu == CPU_W'(c))) ? (lane_act & lane_banked) : '0;

      prio_byte_array #(.DEPTH(NUM_BANKED)) u_bank (
         .clk(clk), .rst_n(rst_n), .wr_en(we), .idx(lane_bidx),
         .wr_data(req_wdata), .rd_data(bank_rd[c*DATA_W +: DATA_W]),
         .lk_idx(BANK_W'(int'(lk_irq))), .lk_data(bank_lk[c*BYTE_W +: BYTE_W])
      );
   end

   assign shr_we = wr_fire ? (lane_act & ~lane_banked) : '0;

   prio_byte_array #(.DEPTH(NUM_SHARED)) u_shared (
      .clk(clk), .rst_n(rst_n), .wr_en(shr_we), .idx(lane_sidx),
      .wr_data(req_wdata), .rd_data(shr_rd),
      .lk_idx(SH_W'(int'(lk_irq) - NUM_BANKED)), .lk_data(shr_lk)
   );

   prio_read_merge #(
      .NUM_CPUS(NUM_CPUS), .NUM_IRQS(NUM_IRQS), .NUM_BANKED(NUM_BANKED)
   ) u_merge (
      .req_cpu(req_cpu), .lane_act(lane_act), .lane_banked(lane_banked),
      .bank_rd(bank_rd), .shr_rd(shr_rd), .lk_cpu(lk_cpu), .lk_irq(lk_irq),
      .bank_lk(bank_lk), .shr_lk(shr_lk), .rd_word(rd_word), .lk_prio(lk_prio)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && dec_err;
         rsp_rdata <= (req_valid && !req_write && !dec_err) ? rd_word : '0;
      end
   end

   p_rsp_follows_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_rsp_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   p_err_no_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_rdata == '0));
   p_bad_size_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size != 3'd1 && req_size != 3'd2 && req_size != 3'd4) |=> rsp_err);
   p_overrun_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (int'(req_addr) + int'(req_size) > NUM_IRQS)) |=> rsp_err);
   p_write_no_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> (rsp_rdata == '0));
endmodule

// File: tb/prio_bank_regfile_tb_top.sv
module prio_bank_regfile_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]  req_cpu = '0;
   logic [7:0]  req_addr = '0;
   logic [2:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;
   logic [1:0]  lk_cpu = '0;
   logic [5:0]  lk_irq = '0;
   logic [7:0]  lk_prio;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   prio_bank_regfile dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_cpu(req_cpu), .req_addr(req_addr), .req_size(req_size),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
      .rsp_rdata(rsp_rdata), .lk_cpu(lk_cpu), .lk_irq(lk_irq), .lk_prio(lk_prio)
   );

   typedef struct packed {
      logic        wr;
      logic [1:0]  cpu;
      logic [7:0]  addr;
      logic [2:0]  sz;
      logic [31:0] wd;
      logic [31:0] exp;
      logic        eerr;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 25;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 2'd0, 8'd0,  3'd4, 32'h0,        32'h0,        1'b0, 4'd1}, // R1
      '{1'b0, 2'd3, 8'd60, 3'd4, 32'h0,        32'h0,        1'b0, 4'd1}, // R1
      '{1'b1, 2'd0, 8'd0,  3'd4, 32'h44332211, 32'h0,        1'b0, 4'd2}, // R2
      '{1'b1, 2'd1, 8'd0,  3'd4, 32'h88776655, 32'h0,        1'b0, 4'd2}, // R2
      '{1'b0, 2'd0, 8'd0,  3'd4, 32'h0,        32'h44332211, 1'b0, 4'd2}, // R2
      '{1'b0, 2'd1, 8'd0,  3'd4, 32'h0,        32'h88776655, 1'b0, 4'd2}, // R2
      '{1'b0, 2'd2, 8'd0,  3'd4, 32'h0,        32'h0,        1'b0, 4'd2}, // R2
      '{1'b1, 2'd2, 8'd40, 3'd2, 32'h0000BBAA, 32'h0,        1'b0, 4'd3}, // R3
      '{1'b0, 2'd0, 8'd40, 3'd2, 32'h0,        32'h0000BBAA, 1'b0, 4'd3}, // R3
      '{1'b0, 2'd3, 8'd40, 3'd4, 32'h0,        32'h0000BBAA, 1'b0, 4'd3}, // R3
      '{1'b1, 2'd3, 8'd17, 3'd1, 32'hFFFFFF5C, 32'h0,        1'b0, 4'd4}, // R4
      '{1'b0, 2'd3, 8'd16, 3'd4, 32'h0,        32'h00005C00, 1'b0, 4'd4}, // R4
      '{1'b0, 2'd3, 8'd17, 3'd2, 32'h0,        32'h0000005C, 1'b0, 4'd4}, // R4
      '{1'b1, 2'd2, 8'd50, 3'd2, 32'hFFFF1234, 32'h0,        1'b0, 4'd4}, // R4
      '{1'b0, 2'd1, 8'd51, 3'd1, 32'h0,        32'h00000012, 1'b0, 4'd4}, // R4
      '{1'b1, 2'd1, 8'd30, 3'd4, 32'hD4C3B2A1, 32'h0,        1'b0, 4'd9}, // R9
      '{1'b0, 2'd1, 8'd30, 3'd4, 32'h0,        32'hD4C3B2A1, 1'b0, 4'd9}, // R9
      '{1'b0, 2'd0, 8'd30, 3'd4, 32'h0,        32'hD4C30000, 1'b0, 4'd9}, // R9
      '{1'b1, 2'd0, 8'd0,  3'd3, 32'hFFFFFFFF, 32'h0,        1'b1, 4'd5}, // R5
      '{1'b0, 2'd0, 8'd0,  3'd4, 32'h0,        32'h44332211, 1'b0, 4'd5}, // R5
      '{1'b0, 2'd0, 8'd0,  3'd0, 32'h0,        32'h0,        1'b1, 4'd5}, // R5
      '{1'b1, 2'd0, 8'd62, 3'd4, 32'hEEEEEEEE, 32'h0,        1'b1, 4'd6}, // R6
      '{1'b0, 2'd0, 8'd60, 3'd4, 32'h0,        32'h0,        1'b0, 4'd6}, // R6
      '{1'b0, 2'd0, 8'd62, 3'd2, 32'h0,        32'h0,        1'b0, 4'd6}, // R6
      '{1'b0, 2'd0, 8'd64, 3'd1, 32'h0,        32'h0,        1'b1, 4'd6}  // R6
   };

   task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", r, act, exp);
      end
   endtask

   // Drive one request at a falling edge; response is sampled at the next falling edge.
   task automatic access(input logic wr, input logic [1:0] cpu, input logic [7:0] addr,
                         input logic [2:0] sz, input logic [31:0] wd);
      req_valid = 1'b1; req_write = wr; req_cpu = cpu;
      req_addr = addr; req_size = sz; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic apply_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      @(negedge clk);
      apply_reset();
      // R1 / R7: reset state of the response
      check("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
      check("R1 rsp_err after reset", {31'b0, rsp_err}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         access(VEC[i].wr, VEC[i].cpu, VEC[i].addr, VEC[i].sz, VEC[i].wd);
         check($sformatf("R%0d vec %0d valid (R7)", VEC[i].req, i), {31'b0, rsp_valid}, 32'h1);
         check($sformatf("R%0d vec %0d err", VEC[i].req, i), {31'b0, rsp_err}, {31'b0, VEC[i].eerr});
         check($sformatf("R%0d vec %0d rdata", VEC[i].req, i), rsp_rdata, VEC[i].exp);
      end

      // R7: idle cycle gives no response
      @(negedge clk);
      check("R7 idle rsp_valid", {31'b0, rsp_valid}, 32'h0);

      // R7: write then read on consecutive cycles
      req_valid = 1'b1; req_write = 1'b1; req_cpu = 2'd2;
      req_addr = 8'd20; req_size = 3'd1; req_wdata = 32'h77;
      @(negedge clk);
      check("R7 b2b write valid", {31'b0, rsp_valid}, 32'h1);
      req_write = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      check("R7 b2b read data", rsp_rdata, 32'h77);

      // R8: lookup port, banked and shared
      lk_cpu = 2'd0; lk_irq = 6'd1; #1;
      check("R8 lookup cpu0 irq1", {24'b0, lk_prio}, 32'h22);
      lk_cpu = 2'd1; lk_irq = 6'd1; #1;
      check("R8 lookup cpu1 irq1", {24'b0, lk_prio}, 32'h66);
      lk_cpu = 2'd2; lk_irq = 6'd33; #1;
      check("R8 lookup cpu2 irq33", {24'b0, lk_prio}, 32'hD4);
      lk_cpu = 2'd3; lk_irq = 6'd17; #1;
      check("R8 lookup cpu3 irq17", {24'b0, lk_prio}, 32'h5C);
      lk_cpu = 2'd0; lk_irq = 6'd17; #1;
      check("R8 lookup cpu0 irq17", {24'b0, lk_prio}, 32'h0);
      lk_cpu = 2'd2; lk_irq = 6'd20; #1;
      check("R8 lookup cpu2 irq20", {24'b0, lk_prio}, 32'h77);

      // R1: reset clears every copy
      @(negedge clk);
      apply_reset();
      lk_cpu = 2'd1; lk_irq = 6'd1; #1;
      check("R1 lookup after reset banked", {24'b0, lk_prio}, 32'h0);
      lk_cpu = 2'd0; lk_irq = 6'd40; #1;
      check("R1 lookup after reset shared", {24'b0, lk_prio}, 32'h0);
      @(negedge clk);
      access(1'b0, 2'd1, 8'd30, 3'd4, 32'h0);
      check("R1 read after reset", rsp_rdata, 32'h0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R7 watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule